// File: doc/BRIEF.md
# Configurable UART Character Framer

This block turns bytes written over a small register port into asynchronous serial characters and recovers characters from a serial input line. A 16-bit divisor sets the rate of a sample tick. Each bit lasts sixteen ticks. Software selects the character shape through a line-shape register: 5 to 8 data bits, parity, and the stop length. Parity can be off, odd, even, or forced to a constant. The stop length can be one bit, two bits, or one and a half bits.

The receiver resynchronises the line and confirms a start bit at mid-bit. It samples every later bit at its centre. It flags parity errors and framing errors. Three interrupt sources are ranked and reported through an identification register. An output-gate bit must be set before the interrupt pin can rise.

Characters are sent and received one at a time. Each direction has a single holding register, and nothing is queued beyond it.

Top module: `uart_framer`

## Requirements
- R1: After reset, txd is 1 and irq is 0. Status (address 5) reads 0x60, identification (address 2) reads 0x01, and line shape (address 3) reads 0x03. The divisor is 0.
- R2: Writing address 0 queues a byte. The byte goes out as one start bit (0), then the data bits least significant first, then stop bits at 1. Word length is line-shape bits [1:0]: 0 means 5 bits and 3 means 8 bits.
- R3: Line-shape bit 3 enables a parity bit after the data. When bit 5 is 0, bit 4 = 1 gives even parity and bit 4 = 0 gives odd parity. When bit 5 is 1 the parity bit is constant: it equals bit 4, so even selection sends 1 and odd selection sends 0.
- R4: With line-shape bit 2 = 0 there is one stop bit. With bit 2 = 1 the stop length is 1.5 bits for 5-bit words and 2 bits otherwise. Back-to-back characters start exactly one frame length apart.
- R5: A received character is readable at address 0, right-aligned. It sets status bit 0, and reading address 0 clears that bit.
- R6: A low pulse on rxd that is gone before mid-bit is not taken as a start bit, and no character is received.
- R7: A parity mismatch sets status bit 2. A 0 in the first stop bit sets status bit 3. The data is still delivered, and reading status clears both bits.
- R8: The divisor (address 6 low byte, address 7 high byte) makes one tick every N clocks, so one bit lasts 16·N clocks. A divisor of 0 stops the ticks, and a queued byte is not sent.
- R9: Identification reports the highest enabled pending source. Line error reads 0x06, received data reads 0x04, holding empty reads 0x02, and nothing pending reads 0x01. Enables are at address 1: bit 2 line error, bit 0 received data, bit 1 holding empty.
- R10: irq is the OR of the enabled pending sources, gated by control bit 0 at address 4. irq is 0 whenever that bit is 0.
- R11: The holding-empty source becomes pending when the transmitter takes the queued byte. It is cleared by a write to address 0, or by a read of identification that reports it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe; reads with side effects act at the clock edge |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational from addr |
| rxd | input | 1 | Serial input, asynchronous |
| txd | output | 1 | Serial output, idle high |
| irq | output | 1 | Gated interrupt request |

## Verification
Two things can change the interrupt state at nearly the same moment. The receiver can finish a character with a parity error, and the transmitter can hand off its holding register and make the holding-empty source pending. The bench provokes this by feeding a bad-parity character on rxd while a byte is being queued and sent. It then reads identification repeatedly. It expects the line-error code first, the received-data code after status is read, and the holding-empty code after the data is read. Only then, once identification itself has been read, does it expect nothing pending.

// File: rtl/uart_framer_pkg.sv
package uart_framer_pkg;

    localparam int OSR     = 16;
    localparam int HALF    = OSR / 2;
    localparam int TCNT_W  = $clog2(2 * OSR);
    localparam int RCNT_W  = $clog2(OSR);

    localparam logic [2:0] A_DATA  = 3'd0;
    localparam logic [2:0] A_IEN   = 3'd1;
    localparam logic [2:0] A_IDENT = 3'd2;
    localparam logic [2:0] A_SHAPE = 3'd3;
    localparam logic [2:0] A_CTRL  = 3'd4;
    localparam logic [2:0] A_STAT  = 3'd5;
    localparam logic [2:0] A_DIVL  = 3'd6;
    localparam logic [2:0] A_DIVH  = 3'd7;

    localparam logic [7:0] ID_NONE = 8'h01;
    localparam logic [7:0] ID_LERR = 8'h06;
    localparam logic [7:0] ID_RDA  = 8'h04;
    localparam logic [7:0] ID_THRE = 8'h02;

    typedef enum logic [2:0] {
        FR_IDLE, FR_START, FR_DATA, FR_PAR, FR_STOP
    } frame_st_e;

    typedef struct packed {
        logic       par_fixed;
        logic       par_even;
        logic       par_en;
        logic       stop_long;
        logic [1:0] wlen;
    } line_cfg_t;

    localparam line_cfg_t LINE_RST = '{par_fixed: 1'b0, par_even: 1'b0,
                                       par_en: 1'b0, stop_long: 1'b0, wlen: 2'd3};

    function automatic logic [3:0] word_bits(input logic [1:0] wl);
        return 4'd5 + {2'b00, wl};
    endfunction

    function automatic logic [7:0] word_mask(input logic [1:0] wl);
        return 8'hFF >> (2'd3 - wl);
    endfunction

    function automatic logic par_of(input line_cfg_t c, input logic [7:0] d);
        logic p;
        p = ^(d & word_mask(c.wlen));
        if (c.par_fixed) return c.par_even;
        return c.par_even ? p : ~p;
    endfunction

    function automatic logic [TCNT_W-1:0] stop_last(input line_cfg_t c);
        if (!c.stop_long)       return TCNT_W'(OSR - 1);
        else if (c.wlen == 2'd0) return TCNT_W'(OSR + HALF - 1);
        else                     return TCNT_W'(2 * OSR - 1);
    endfunction

    function automatic logic [7:0] rx_align(input logic [7:0] sh, input logic [1:0] wl);
        return sh >> (2'd3 - wl);
    endfunction

endpackage

// File: rtl/uart_tick_gen.sv
module uart_tick_gen #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic [DIV_W-1:0] divisor,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || restart || divisor == '0) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (cnt == divisor - DIV_W'(1)) begin
            cnt  <= '0;
            tick <= 1'b1;
        end else begin
            cnt  <= cnt + DIV_W'(1);
            tick <= 1'b0;
        end
    end
endmodule

// File: rtl/uart_tx_ser.sv
module uart_tx_ser
    import uart_framer_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      tick,
    input  line_cfg_t cfg,
    input  logic      hold_full,
    input  logic [7:0] hold_data,
    output logic      take,
    output logic      txd,
    output logic      idle
);
    frame_st_e          st;
    logic [TCNT_W-1:0]  cnt;
    logic [7:0]         sh;
    logic [2:0]         bitn;
    logic               pbit;
    line_cfg_t          cq;
    logic               bit_end;
    logic               stop_end;

    assign bit_end  = (cnt == TCNT_W'(OSR - 1));
    assign stop_end = (cnt == stop_last(cq));
    assign take     = tick && hold_full && (st == FR_IDLE || (st == FR_STOP && stop_end));
    assign idle     = (st == FR_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= FR_IDLE;
            cnt  <= '0;
            sh   <= '0;
            bitn <= '0;
            pbit <= 1'b0;
            cq   <= LINE_RST;
            txd  <= 1'b1;
        end else if (take) begin
            st   <= FR_START;
            cnt  <= '0;
            sh   <= hold_data;
            bitn <= '0;
            pbit <= par_of(cfg, hold_data);
            cq   <= cfg;
            txd  <= 1'b0;
        end else if (tick) begin
            case (st)
                FR_IDLE: ;
                FR_START: begin
                    if (bit_end) begin
                        cnt <= '0;
                        st  <= FR_DATA;
                        txd <= sh[0];
                    end else cnt <= cnt + TCNT_W'(1);
                end
                FR_DATA: begin
                    if (bit_end) begin
                        cnt <= '0;
                        if ({1'b0, bitn} == word_bits(cq.wlen) - 4'd1) begin
                            if (cq.par_en) begin
                                st  <= FR_PAR;
                                txd <= pbit;
                            end else begin
                                st  <= FR_STOP;
                                txd <= 1'b1;
                            end
                        end else begin
                            bitn <= bitn + 3'd1;
                            sh   <= {1'b0, sh[7:1]};
                            txd  <= sh[1];
                        end
                    end else cnt <= cnt + TCNT_W'(1);
                end
                FR_PAR: begin
                    if (bit_end) begin
                        cnt <= '0;
                        st  <= FR_STOP;
                        txd <= 1'b1;
                    end else cnt <= cnt + TCNT_W'(1);
                end
                FR_STOP: begin
                    if (stop_end) begin
                        cnt <= '0;
                        st  <= FR_IDLE;
                    end else cnt <= cnt + TCNT_W'(1);
                end
                default: st <= FR_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/uart_rx_deser.sv
module uart_rx_deser
    import uart_framer_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  line_cfg_t  cfg,
    input  logic       rxd_async,
    output logic       done,
    output logic [7:0] data,
    output logic       perr,
    output logic       ferr
);
    logic [1:0]        sync;
    logic              rx;
    frame_st_e         st;
    logic [RCNT_W-1:0] cnt;
    logic [7:0]        sh;
    logic [2:0]        bitn;
    logic              prx;
    line_cfg_t         cq;
    logic              bit_end;
    logic [7:0]        aligned;

    assign rx      = sync[1];
    assign bit_end = (cnt == RCNT_W'(OSR - 1));
    assign aligned = rx_align(sh, cq.wlen);

    always_ff @(posedge clk) begin
        if (rst) sync <= 2'b11;
        else     sync <= {sync[0], rxd_async};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= FR_IDLE;
            cnt  <= '0;
            sh   <= '0;
            bitn <= '0;
            prx  <= 1'b0;
            cq   <= LINE_RST;
            done <= 1'b0;
            data <= '0;
            perr <= 1'b0;
            ferr <= 1'b0;
        end else begin
            done <= 1'b0;
            if (tick) begin
                case (st)
                    FR_IDLE: begin
                        if (!rx) begin
                            st  <= FR_START;
                            cnt <= '0;
                            cq  <= cfg;
                        end
                    end
                    FR_START: begin
                        if (cnt == RCNT_W'(HALF - 1)) begin
                            cnt  <= '0;
                            bitn <= '0;
                            st   <= rx ? FR_IDLE : FR_DATA;
                        end else cnt <= cnt + RCNT_W'(1);
                    end
                    FR_DATA: begin
                        if (bit_end) begin
                            cnt <= '0;
                            sh  <= {rx, sh[7:1]};
                            if ({1'b0, bitn} == word_bits(cq.wlen) - 4'd1)
                                st <= cq.par_en ? FR_PAR : FR_STOP;
                            else
                                bitn <= bitn + 3'd1;
                        end else cnt <= cnt + RCNT_W'(1);
                    end
                    FR_PAR: begin
                        if (bit_end) begin
                            cnt <= '0;
                            prx <= rx;
                            st  <= FR_STOP;
                        end else cnt <= cnt + RCNT_W'(1);
                    end
                    FR_STOP: begin
                        if (bit_end) begin
                            cnt  <= '0;
                            st   <= FR_IDLE;
                            done <= 1'b1;
                            data <= aligned;
                            perr <= cq.par_en && (prx != par_of(cq, aligned));
                            ferr <= !rx;
                        end else cnt <= cnt + RCNT_W'(1);
                    end
                    default: st <= FR_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/uart_irq_arb.sv
module uart_irq_arb
    import uart_framer_pkg::*;
(
    input  logic [2:0] ien,
    input  logic       dr,
    input  logic       line_err,
    input  logic       thre_pend,
    input  logic       gate,
    output logic [7:0] ident,
    output logic       irq,
    output logic       thre_sel
);
    logic src_ls, src_rda, src_th;

    assign src_ls  = ien[2] & line_err;
    assign src_rda = ien[0] & dr;
    assign src_th  = ien[1] & thre_pend;

    always_comb begin
        if (src_ls)       ident = ID_LERR;
        else if (src_rda) ident = ID_RDA;
        else if (src_th)  ident = ID_THRE;
        else              ident = ID_NONE;
    end

    assign thre_sel = src_th & ~src_ls & ~src_rda;
    assign irq      = gate & (src_ls | src_rda | src_th);
endmodule

// File: rtl/uart_framer.sv
module uart_framer
    import uart_framer_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic       rd_en,
    input  logic [2:0] addr,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    input  logic       rxd,
    output logic       txd,
    output logic       irq
);
    localparam int DIV_HI = DIV_W - 8;

    logic [DIV_W-1:0] divisor;
    logic [5:0]       shape_q;
    logic [2:0]       ien_q;
    logic             out2_q;
    logic [7:0]       hold_q;
    logic             hold_full;
    logic [7:0]       rbuf_q;
    logic             dr_q, pe_q, fe_q, thre_pend;

    logic             tick, restart, take, tx_idle, thre_sel;
    logic             rx_done, rx_perr, rx_ferr;
    logic [7:0]       rx_data, ident, status;
    line_cfg_t        cfg;

    logic wr_data, rd_data, rd_stat, rd_ident;

    assign cfg      = line_cfg_t'(shape_q);
    assign restart  = wr_en && (addr == A_DIVL || addr == A_DIVH);
    assign wr_data  = wr_en && addr == A_DATA;
    assign rd_data  = rd_en && addr == A_DATA;
    assign rd_stat  = rd_en && addr == A_STAT;
    assign rd_ident = rd_en && addr == A_IDENT;
    assign status   = {1'b0, tx_idle & ~hold_full, ~hold_full, 1'b0, fe_q, pe_q, 1'b0, dr_q};

    uart_tick_gen #(.DIV_W(DIV_W)) u_tick (
        .clk(clk), .rst(rst), .restart(restart), .divisor(divisor), .tick(tick)
    );

    uart_tx_ser u_tx (
        .clk(clk), .rst(rst), .tick(tick), .cfg(cfg), .hold_full(hold_full),
        .hold_data(hold_q), .take(take), .txd(txd), .idle(tx_idle)
    );

    uart_rx_deser u_rx (
        .clk(clk), .rst(rst), .tick(tick), .cfg(cfg), .rxd_async(rxd),
        .done(rx_done), .data(rx_data), .perr(rx_perr), .ferr(rx_ferr)
    );

    uart_irq_arb u_irq (
        .ien(ien_q), .dr(dr_q), .line_err(pe_q | fe_q), .thre_pend(thre_pend),
        .gate(out2_q), .ident(ident), .irq(irq), .thre_sel(thre_sel)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            divisor <= '0;
            shape_q <= LINE_RST;
            ien_q   <= '0;
            out2_q  <= 1'b0;
        end else if (wr_en) begin
            case (addr)
                A_IEN:   ien_q   <= wdata[2:0];
                A_SHAPE: shape_q <= wdata[5:0];
                A_CTRL:  out2_q  <= wdata[0];
                A_DIVL:  divisor[7:0] <= wdata;
                A_DIVH:  divisor[DIV_W-1:8] <= wdata[DIV_HI-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q    <= '0;
            hold_full <= 1'b0;
            thre_pend <= 1'b0;
        end else begin
            if (take) begin
                hold_full <= 1'b0;
                thre_pend <= 1'b1;
            end
            if (wr_data) begin
                hold_q    <= wdata;
                hold_full <= 1'b1;
                thre_pend <= 1'b0;
            end
            if (rd_ident && thre_sel) thre_pend <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rbuf_q <= '0;
            dr_q   <= 1'b0;
            pe_q   <= 1'b0;
            fe_q   <= 1'b0;
        end else begin
            if (rd_data) dr_q <= 1'b0;
            if (rd_stat) begin
                pe_q <= 1'b0;
                fe_q <= 1'b0;
            end
            if (rx_done) begin
                rbuf_q <= rx_data;
                dr_q   <= 1'b1;
                if (rx_perr) pe_q <= 1'b1;
                if (rx_ferr) fe_q <= 1'b1;
            end
        end
    end

    always_comb begin
        case (addr)
            A_DATA:  rdata = rbuf_q;
            A_IEN:   rdata = {5'b0, ien_q};
            A_IDENT: rdata = ident;
            A_SHAPE: rdata = {2'b0, shape_q};
            A_CTRL:  rdata = {7'b0, out2_q};
            A_STAT:  rdata = status;
            A_DIVL:  rdata = divisor[7:0];
            default: rdata = 8'(divisor[DIV_W-1:8]);
        endcase
    end
endmodule

// File: rtl/uart_framer_chk.sv
module uart_framer_chk #(
    parameter int DIV_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             irq,
    input logic             out2_q,
    input logic             txd,
    input logic             tx_idle,
    input logic             rd_en,
    input logic [2:0]       addr,
    input logic             rx_done,
    input logic             dr_q,
    input logic             pe_q,
    input logic             fe_q,
    input logic [2:0]       ien_q,
    input logic [7:0]       ident,
    input logic [DIV_W-1:0] divisor,
    input logic             tick
);
    assert_irq_gate_R10: assert property (@(posedge clk) disable iff (rst)
        !out2_q |-> !irq);

    assert_idle_mark_R1: assert property (@(posedge clk) disable iff (rst)
        tx_idle |-> txd);

    assert_lerr_first_R9: assert property (@(posedge clk) disable iff (rst)
        (ien_q[2] && (pe_q || fe_q)) |-> ident == 8'h06);

    assert_dr_clear_R5: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr == 3'd0 && !rx_done) |=> !dr_q);

    assert_err_clear_R7: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr == 3'd5 && !rx_done) |=> (!pe_q && !fe_q));

    assert_div_zero_R8: assert property (@(posedge clk) disable iff (rst)
        (divisor == '0) |=> !tick);
endmodule

bind uart_framer uart_framer_chk #(.DIV_W(DIV_W)) u_chk (
    .clk(clk), .rst(rst), .irq(irq), .out2_q(out2_q), .txd(txd), .tx_idle(tx_idle),
    .rd_en(rd_en), .addr(addr), .rx_done(rx_done), .dr_q(dr_q), .pe_q(pe_q),
    .fe_q(fe_q), .ien_q(ien_q), .ident(ident), .divisor(divisor), .tick(tick)
);

// File: tb/tb_uart_framer.sv
`timescale 1ns/1ps
module tb_uart_framer;
    // Divisor 0 choice: ticks are inhibited, nothing is sent (R8).
    logic       clk = 0, rst = 1, wr_en = 0, rd_en = 0, rxd = 1;
    logic [2:0] addr = 0;
    logic [7:0] wdata = 0;
    logic [7:0] rdata;
    logic       txd, irq;

    uart_framer dut (.clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
                     .wdata(wdata), .rdata(rdata), .rxd(rxd), .txd(txd), .irq(irq));

    always #2 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int checks = 0, errors = 0;
    int sb[$];
    int starts[$];
    bit mon_busy = 0;
    int cur_div = 0;
    int b_bits = 8;
    bit b_pen = 0, b_peven = 0, b_pfix = 0, b_long = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk); wr_en = 1; addr = 3'(a); wdata = 8'(d);
        @(negedge clk); wr_en = 0;
    endtask

    task automatic rd(input int a, output int d);
        @(negedge clk); rd_en = 1; addr = 3'(a);
        #1 d = int'(rdata);
        @(negedge clk); rd_en = 0;
    endtask

    task automatic set_shape(input int v);
        wr(3, v);
        b_bits = 5 + (v & 3); b_long = v[2]; b_pen = v[3]; b_peven = v[4]; b_pfix = v[5];
    endtask

    function automatic int exp_par(input int d);
        int p;
        p = $countones(d & ((1 << b_bits) - 1)) & 1;
        if (b_pfix) return int'(b_peven);
        return b_peven ? p : 1 - p;
    endfunction

    function automatic int gap_exp();
        int st;
        st = !b_long ? 16 : (b_bits == 5 ? 24 : 32);
        return ((1 + b_bits + int'(b_pen)) * 16 + st) * cur_div;
    endfunction

    // driver: pushes expected frame into the scoreboard, then queues the byte
    task automatic tx_send(input int d);
        int s;
        do rd(5, s); while ((s & 32) == 0);
        sb.push_back((d & 255) | (b_pen ? ((exp_par(d) << 8) | 512) : 0));
        wr(0, d);
    endtask

    task automatic drain();
        int s;
        do @(negedge clk); while (sb.size() != 0 || mon_busy);
        do rd(5, s); while ((s & 64) == 0);
    endtask

    task automatic pair_gap(input int d1, input int d2, input string tag);
        int e;
        starts.delete();
        tx_send(d1); tx_send(d2); drain();
        e = gap_exp();
        check(starts.size() == 2 && starts[1] - starts[0] == e, tag,
              starts.size() == 2 ? starts[1] - starts[0] : -1, e);
    endtask

    task automatic hold_bit(input bit v);
        rxd = v;
        repeat (16 * cur_div) @(negedge clk);
    endtask

    task automatic rx_send(input int d, input int nb, input int pb, input bit stopv);
        @(negedge clk);
        hold_bit(0);
        for (int i = 0; i < nb; i++) hold_bit(d[i]);
        if (pb >= 0) hold_bit(pb[0]);
        hold_bit(stopv);
        rxd = 1;
    endtask

    task automatic wait_cyc(input int t);
        while (cyc < t) @(negedge clk);
    endtask

    // monitor: decodes txd frames and compares with scoreboard
    initial begin
        bit prev = 1;
        forever begin
            @(negedge clk);
            if (!rst && txd === 1'b0 && prev) begin
                int t0, d, nb, data, pbit, stopv, e;
                bit pen;
                t0 = cyc; d = cur_div; nb = b_bits; pen = b_pen;
                mon_busy = 1;
                starts.push_back(t0);
                data = 0;
                for (int i = 0; i < nb; i++) begin
                    wait_cyc(t0 + (16 * (i + 1) + 8) * d);
                    data |= int'(txd) << i;
                end
                pbit = 0;
                if (pen) begin
                    wait_cyc(t0 + (16 * (nb + 1) + 8) * d);
                    pbit = int'(txd);
                end
                wait_cyc(t0 + (16 * (nb + 1 + int'(pen)) + 8) * d);
                stopv = int'(txd);
                check(stopv == 1, "R2 stop bit", stopv, 1);
                if (sb.size() == 0) begin
                    check(0, "R2 unexpected frame", data, -1);
                end else begin
                    e = sb.pop_front();
                    check(data == (e & 255), "R2 data bits", data, e & 255);
                    if (e & 512) check(pbit == ((e >> 8) & 1), "R3 parity bit", pbit, (e >> 8) & 1);
                end
                mon_busy = 0;
                prev = 1;
            end else begin
                prev = txd;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired actual=%0d expected=done", cyc);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int v, lows;
        repeat (5) @(negedge clk);
        rst = 0;
        // R1 reset state
        rd(5, v); check(v == 8'h60, "R1 status", v, 8'h60);
        rd(2, v); check(v == 8'h01, "R1 ident", v, 8'h01);
        rd(3, v); check(v == 8'h03, "R1 shape", v, 8'h03);
        check(txd == 1 && irq == 0, "R1 pins", {txd, irq}, 2'b10);

        // R8 divisor 0 inhibits transmission
        set_shape(8'h03);
        tx_send(8'h55);
        lows = 0;
        repeat (400) begin @(negedge clk); if (!txd) lows++; end
        check(lows == 0 && sb.size() == 1, "R8 divisor zero holds", lows, 0);
        starts.delete();
        cur_div = 2; wr(6, 2); wr(7, 0);
        tx_send(8'hA3); drain();
        check(starts.size() == 2 && starts[1] - starts[0] == 320, "R8 div2 frame time",
              starts.size() == 2 ? starts[1] - starts[0] : -1, 320);
        cur_div = 3; wr(6, 3);
        pair_gap(8'h0F, 8'hF0, "R8 div3 frame time");
        cur_div = 2; wr(6, 2);

        // R3 parity modes
        set_shape(8'h1A); tx_send(8'h35); drain();
        set_shape(8'h0B); tx_send(8'hA3); drain();
        set_shape(8'h3B); tx_send(8'h12); drain();
        set_shape(8'h2B); tx_send(8'h7E); drain();

        // R4 stop lengths
        set_shape(8'h04); pair_gap(8'h15, 8'h0A, "R4 5-bit 1.5 stop");
        set_shape(8'h05); pair_gap(8'h2C, 8'h13, "R4 6-bit 2 stop");
        set_shape(8'h00); pair_gap(8'h1F, 8'h01, "R4 5-bit 1 stop");
        set_shape(8'h07); pair_gap(8'h81, 8'h7E, "R4 8-bit 2 stop");

        // R5 receive
        set_shape(8'h03);
        rx_send(8'hC6, 8, -1, 1); repeat (20) @(negedge clk);
        rd(5, v); check((v & 8'h0D) == 8'h01, "R5 data ready", v & 8'h0D, 1);
        rd(0, v); check(v == 8'hC6, "R5 rx data", v, 8'hC6);
        rd(5, v); check((v & 1) == 0, "R5 ready cleared", v & 1, 0);
        set_shape(8'h00);
        rx_send(8'h1B, 5, -1, 1); repeat (20) @(negedge clk);
        rd(0, v); check(v == 8'h1B, "R5 5-bit rx data", v, 8'h1B);

        // R6 glitch rejection
        set_shape(8'h03);
        @(negedge clk); rxd = 0; repeat (10) @(negedge clk); rxd = 1;
        repeat (200) @(negedge clk);
        rd(5, v); check((v & 1) == 0, "R6 glitch ignored", v & 1, 0);

        // R7 parity and framing errors
        set_shape(8'h1A);
        rx_send(8'h35, 7, 1, 1); repeat (20) @(negedge clk);
        rd(5, v); check((v & 8'h0D) == 8'h05, "R7 parity error", v & 8'h0D, 8'h05);
        rd(5, v); check((v & 8'h0C) == 0, "R7 errors cleared", v & 8'h0C, 0);
        rd(0, v); check(v == 8'h35, "R7 data kept", v, 8'h35);
        rx_send(8'h35, 7, 0, 1); repeat (20) @(negedge clk);
        rd(5, v); check((v & 8'h0C) == 0, "R7 good parity", v & 8'h0C, 0);
        rd(0, v);
        set_shape(8'h03);
        rx_send(8'h5A, 8, -1, 0); repeat (200) @(negedge clk);
        rd(5, v); check((v & 8'h0C) == 8'h08, "R7 framing error", v & 8'h0C, 8'h08);
        rd(5, v); check((v & 8'h0C) == 0, "R7 framing cleared", v & 8'h0C, 0);
        rd(0, v); check(v == 8'h5A, "R7 framing data", v, 8'h5A);

        // R10 / R11 gating and holding-empty source
        set_shape(8'h1A);
        wr(1, 7);
        @(negedge clk); check(irq == 0, "R10 gate off", irq, 0);
        wr(4, 1);
        @(negedge clk); check(irq == 1, "R10 gate on", irq, 1);
        rd(2, v); check(v == 8'h02, "R11 empty reported", v, 8'h02);
        rd(2, v); check(v == 8'h01, "R11 ident read clears", v, 8'h01);
        check(irq == 0, "R10 irq drops", irq, 0);

        // R9 concurrent receive error and transmit hand-off
        fork
            rx_send(8'h35, 7, 1, 1);
            tx_send(8'h44);
        join
        repeat (50) @(negedge clk);
        rd(2, v); check(v == 8'h06, "R9 line error first", v, 8'h06);
        check(irq == 1, "R10 irq with error", irq, 1);
        rd(5, v);
        rd(2, v); check(v == 8'h04, "R9 data next", v, 8'h04);
        rd(0, v);
        rd(2, v); check(v == 8'h02, "R9 empty last", v, 8'h02);
        rd(2, v); check(v == 8'h01, "R11 cleared", v, 8'h01);
        drain();

        // R11 write clears the pending empty source
        cur_div = 0; wr(6, 0);
        rd(2, v);
        tx_send(8'h66);
        rd(2, v); check(v == 8'h01, "R11 write clears", v, 8'h01);
        cur_div = 2; wr(6, 2);
        drain();
        rd(2, v); check(v == 8'h02, "R11 set on hand-off", v, 8'h02);

        check(sb.size() == 0, "R2 scoreboard empty", sb.size(), 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule